// File: doc/BRIEF.md
# Multi-Mode Ripple Arithmetic Chain

This block is a cascade of 4-bit arithmetic slices that share one ripple carry path. A two-bit mode input makes the whole chain act as one of four operators: an up/down counter, one row of a shift-and-add multiplier, an equality comparator or a magnitude comparator. Each slice takes a 4-bit field of the A and B words. Its carry-out feeds the carry-in of the next more significant slice, and the chain's final carry-out is the result bit that matters in the compare modes. The word width is four times the slice-count parameter.

Every slice has a 4-bit register that can capture the slice result. In counter mode the slices read their register instead of the A input, so the chain holds and advances a count with no outside feedback. In multiply mode the control bit is the multiplier bit: the chain adds either the multiplicand or zero to an incoming partial product, and the carry-out is the next product bit. Equality mode raises the carry-out on any mismatch. Magnitude mode subtracts B from A in two's complement, and a carry-out of 1 means A is not below B.

There is no sequencing state machine. The only state is the count register, which has a synchronous active-low reset and a clock enable.

Top module: `arith_ripple_chain`

## Requirements
- R1: After a clock edge with `rst_n` low, `q_out` is 0.
- R2: With `mode`=0 (count) and `ctl`=1, `f_out` = (`q_out` + 1) mod 2^W, and `cout` is 1 exactly when `q_out` is all ones.
- R3: With `mode`=0 and `ctl`=0, `f_out` = (`q_out` − 1) mod 2^W, and `cout` is 1 exactly when `q_out` is 0.
- R4: At a clock edge with `rst_n` high, `q_out` takes the value `f_out` had before the edge when `en` is 1, and keeps its value when `en` is 0.
- R5: In count mode, `a_in`, `b_in` and `cin` have no effect on `f_out` or `cout`.
- R6: With `mode`=1 (multiply), {`cout`,`f_out`} = `a_in` + (`ctl` ? `b_in` : 0) + `cin`.
- R7: With `mode`=2 (equality), `cout` = 1 when `a_in` ≠ `b_in` and 0 when they are equal, `f_out` = `a_in` XOR `b_in`, and `cin` is ignored.
- R8: With `mode`=3 (magnitude), `f_out` = (`a_in` − `b_in`) mod 2^W, `cout` = 1 when `a_in` ≥ `b_in` as unsigned numbers, and `cin` is ignored.
- R9: Carries and borrows pass between slices, so R2 to R8 hold across the full W = 4·NSLICE bits. This includes a count that wraps at either end and a mismatch found only in the top slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the count register |
| en | input | 1 | Register capture enable |
| mode | input | 2 | 0 count, 1 multiply, 2 equality, 3 magnitude |
| ctl | input | 1 | Count direction (1 up) or multiplier bit |
| a_in | input | W | Operand A or partial product |
| b_in | input | W | Operand B or multiplicand |
| cin | input | 1 | Carry into the least significant slice (multiply mode only) |
| f_out | output | W | Result word |
| cout | output | 1 | Carry, borrow or mismatch out of the top slice |
| q_out | output | W | Register contents |

## Verification
The register is the only state, and every bit of it is on `q_out`. A bad capture or a bad reset therefore shows on the cycle right after the clock edge. In count mode that error is also folded into `f_out` and `cout` within the same cycle. A broken carry link between slices stays hidden until an operand makes a carry, borrow or mismatch cross that boundary. For this reason the stimulus deliberately places wrap values such as 0x0FF and 0xFFF, and differences confined to the top slice.

// File: rtl/arith_slice_pkg.sv
package arith_slice_pkg;
    localparam int SLICE_W = 4;

    typedef enum logic [1:0] {
        MODE_COUNT = 2'd0,
        MODE_MULT  = 2'd1,
        MODE_EQ    = 2'd2,
        MODE_MAG   = 2'd3
    } op_mode_e;
endpackage

// File: rtl/arith_slice_cell.sv
module arith_slice_cell
    import arith_slice_pkg::*;
#(
    parameter int SW = SLICE_W
) (
    input  op_mode_e        mode,
    input  logic            ctl,
    input  logic [SW-1:0]   a,
    input  logic [SW-1:0]   b,
    input  logic            ci,
    output logic [SW-1:0]   f,
    output logic            co
);
    logic [SW:0] sum_w;
    logic [SW-1:0] addend;

    always_comb begin
        sum_w  = '0;
        addend = '0;
        f      = '0;
        co     = 1'b0;
        unique case (mode)
            MODE_COUNT: begin
                if (ctl) begin
                    sum_w = {1'b0, a} + {{SW{1'b0}}, ci};
                    f     = sum_w[SW-1:0];
                    co    = sum_w[SW];
                end else begin
                    f  = a - {{(SW-1){1'b0}}, ci};
                    co = ci & (a == '0);
                end
            end
            MODE_MULT: begin
                addend = ctl ? b : '0;
                sum_w  = {1'b0, a} + {1'b0, addend} + {{SW{1'b0}}, ci};
                f      = sum_w[SW-1:0];
                co     = sum_w[SW];
            end
            MODE_EQ: begin
                f  = a ^ b;
                co = ci | (a != b);
            end
            MODE_MAG: begin
                sum_w = {1'b0, a} + {1'b0, ~b} + {{SW{1'b0}}, ci};
                f     = sum_w[SW-1:0];
                co    = sum_w[SW];
            end
            default: begin
                f  = '0;
                co = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/arith_slice_reg.sv
module arith_slice_reg #(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/arith_ripple_chain.sv
module arith_ripple_chain
    import arith_slice_pkg::*;
#(
    parameter int NSLICE = 3,
    parameter int SW     = SLICE_W,
    parameter int W      = NSLICE * SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    mode,
    input  logic          ctl,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic          cin,
    output logic [W-1:0]  f_out,
    output logic          cout,
    output logic [W-1:0]  q_out
);
    op_mode_e       mode_e;
    logic [NSLICE:0] carry;

    assign mode_e = op_mode_e'(mode);

    always_comb begin
        unique case (mode_e)
            MODE_COUNT: carry[0] = 1'b1;
            MODE_MULT:  carry[0] = cin;
            MODE_EQ:    carry[0] = 1'b0;
            MODE_MAG:   carry[0] = 1'b1;
            default:    carry[0] = 1'b0;
        endcase
    end

    for (genvar gi = 0; gi < NSLICE; gi++) begin : g_slice
        logic [SW-1:0] a_sel;
        logic [SW-1:0] f_s;
        logic [SW-1:0] q_s;

        assign a_sel = (mode_e == MODE_COUNT) ? q_s : a_in[gi*SW +: SW];

        arith_slice_cell #(.SW(SW)) cell_i (
            .mode (mode_e),
            .ctl  (ctl),
            .a    (a_sel),
            .b    (b_in[gi*SW +: SW]),
            .ci   (carry[gi]),
            .f    (f_s),
            .co   (carry[gi+1])
        );

        arith_slice_reg #(.SW(SW)) reg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .d     (f_s),
            .q     (q_s)
        );

        assign f_out[gi*SW +: SW] = f_s;
        assign q_out[gi*SW +: SW] = q_s;
    end

    assign cout = carry[NSLICE];
endmodule

// File: rtl/arith_ripple_chain_chk.sv
module arith_ripple_chain_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [1:0]   mode,
    input logic         ctl,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] f_out,
    input logic         cout,
    input logic [W-1:0] q_out
);
    localparam logic [W-1:0] ONE_W = W'(1);

    AST_LOAD_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q_out == $past(f_out)));                              // R4
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q_out));                                      // R4
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && ctl) |-> (f_out == (q_out + ONE_W)));        // R2
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !ctl) |-> (f_out == (q_out - ONE_W)));       // R3
    AST_EQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (cout == (a_in != b_in)));                 // R7
    AST_MAG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (cout == (a_in >= b_in)));                 // R8
endmodule

bind arith_ripple_chain arith_ripple_chain_chk #(.W(W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .mode  (mode),
    .ctl   (ctl),
    .a_in  (a_in),
    .b_in  (b_in),
    .f_out (f_out),
    .cout  (cout),
    .q_out (q_out)
);

// File: tb/arith_ripple_chain_tb.sv
`timescale 1ns/1ps
module arith_ripple_chain_tb_top;
    localparam int NS   = 3;
    localparam int W    = 4 * NS;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [1:0]   mode = 2'd1;
    logic         ctl = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         cin = 1'b0;
    logic [W-1:0] f_out;
    logic         cout;
    logic [W-1:0] q_out;

    int vectors = 0;
    int errors  = 0;
    int q_model = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    arith_ripple_chain #(.NSLICE(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .ctl(ctl),
        .a_in(a_in), .b_in(b_in), .cin(cin),
        .f_out(f_out), .cout(cout), .q_out(q_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check outputs, let the edge update the model
    task automatic step(input int m, input bit c, input int a, input int b,
                        input bit ci, input bit e, input bit r);
        int ef, ec, s;
        string tg;
        @(negedge clk);
        mode = 2'(m); ctl = c; a_in = W'(a); b_in = W'(b); cin = ci; en = e; rst_n = r;
        #1;
        check("R4 register contents", int'(q_out), q_model);
        case (m)
            0: begin
                if (c) begin
                    ef = (q_model + 1) & MASK; ec = (q_model == MASK); tg = "R2 R5 R9 count up";
                end else begin
                    ef = (q_model - 1) & MASK; ec = (q_model == 0); tg = "R3 R5 R9 count down";
                end
            end
            1: begin
                s = a + (c ? b : 0) + int'(ci);
                ef = s & MASK; ec = (s >> W) & 1; tg = "R6 R9 multiply add";
            end
            2: begin
                ef = (a ^ b) & MASK; ec = (a != b); tg = "R7 R9 equality";
            end
            default: begin
                s = a + ((~b) & MASK) + 1;
                ef = s & MASK; ec = (s >> W) & 1; tg = "R8 R9 magnitude";
            end
        endcase
        check({tg, " f_out"}, int'(f_out), ef);
        check({tg, " cout"}, int'(cout), ec);
        @(posedge clk);
        if (!r) q_model = 0;
        else if (e) q_model = ef;
    endtask

    task automatic load(input int v);
        step(1, 1'b0, v, 0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        #20000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int r1, r2;
        // R1: reset clears register
        load(12'h5A5);
        step(1, 1'b0, 0, 0, 1'b0, 1'b1, 1'b0);
        @(negedge clk); #1;
        check("R1 reset value", int'(q_out), 0);

        // exhaustive low-slice patterns, upper bits random
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                r1 = ($urandom & 12'hFF0) | a;
                r2 = ($urandom & 12'hFF0) | b;
                step(1, a[0], a, b, b[1], 1'b0, 1'b1);
                step(1, 1'b1, r1, r2, a[2], 1'b0, 1'b1);
                step(2, 1'b0, r1, r2, b[0], 1'b0, 1'b1);
                step(2, 1'b0, r1, (r2 & 12'hFF0) | a, 1'b1, 1'b0, 1'b1);
                step(3, 1'b0, a, b, b[2], 1'b0, 1'b1);
                step(3, 1'b0, r1, r2, 1'b0, 1'b0, 1'b1);
            end
        end

        // R9 compare cases: all equal, all different, top-slice-only mismatch
        step(2, 1'b0, 12'hABC, 12'hABC, 1'b1, 1'b0, 1'b1);
        step(2, 1'b0, 12'h000, 12'hFFF, 1'b0, 1'b0, 1'b1);
        step(2, 1'b0, 12'h123, 12'h923, 1'b0, 1'b0, 1'b1);
        step(3, 1'b0, 12'h800, 12'h7FF, 1'b0, 1'b0, 1'b1);
        step(3, 1'b0, 12'h7FF, 12'h800, 1'b1, 1'b0, 1'b1);
        step(1, 1'b1, 12'hFFF, 12'h001, 1'b0, 1'b0, 1'b1);

        // counter wrap and cross-slice ripple (R2 R3 R9), random a/cin (R5)
        load(12'hFFD);
        for (int i = 0; i < 6; i++) step(0, 1'b1, $urandom, $urandom, 1'($urandom), 1'b1, 1'b1);
        load(12'h002);
        for (int i = 0; i < 6; i++) step(0, 1'b0, $urandom, $urandom, 1'($urandom), 1'b1, 1'b1);
        load(12'h0FF);
        step(0, 1'b1, 0, 0, 1'b0, 1'b1, 1'b1);
        step(0, 1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
        // R4 hold with enable low
        for (int i = 0; i < 4; i++) step(0, 1'b1, $urandom, 0, 1'b0, 1'b0, 1'b1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            step($urandom % 4, 1'($urandom), $urandom & MASK, $urandom & MASK,
                 1'($urandom), 1'($urandom), ($urandom % 50) != 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule